// File: doc/BRIEF.md
# Ordered Store Queue with Load Bypass

This block sits between one processor and a shared memory port and gives that processor a total-store-order view of memory. Stores and atomic swaps are parked in a private first-in first-out queue and written to memory strictly in the order the processor handed them over. The processor can move on as soon as a store is queued; it does not wait for memory.

Loads look in the queue first. If one or more queued stores target the same address, the load is answered from the youngest of them without touching memory. If nothing matches, the load goes to memory once the queue has emptied. A swap travels through the queue behind the stores issued before it, performs an atomic read-and-write at memory, and hands the old value back. While a load or swap is waiting for its value, the processor cannot issue anything else. Exactly one memory request is in flight at any time, and every request, writes included, receives exactly one memory response.

Top module: `tso_store_queue`

## Requirements
- R1: After reset the queue is empty, `cpu_req_ready` is 1 and both `mem_req_valid` and `cpu_rsp_valid` are 0.
- R2: Processor op codes are 0 load, 1 store, 2 swap (3 is never accepted). The queue holds DEPTH entries (8 by default); with DEPTH entries held, `cpu_req_ready` is 0 for a store or swap and stays 1 for a load.
- R3: Queued entries reach memory in the order they were accepted; a store appears as memory op 1 (write) with its address and data.
- R4: A load whose address matches one or more queued stores returns the data of the most recently accepted matching store on `cpu_rsp_valid`, one cycle after acceptance, with no memory request.
- R5: A load that matches nothing issues memory op 0 (read) only after every older queued entry has completed at memory, and returns the memory response data on `cpu_rsp_valid` one cycle after `mem_rsp_valid`.
- R6: From the acceptance of a load miss or a swap until its value is returned, `cpu_req_ready` is 0.
- R7: A swap is issued to memory as op 2 only after all stores accepted before it have completed, and returns the value memory held before the swap.
- R8: A memory request holds its op, address and data stable while `mem_req_ready` is 0, and no new request is raised before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid is also high |
| cpu_req_op | input | 2 | 0 load, 1 store, 2 swap |
| cpu_req_addr | input | AW | Request address |
| cpu_req_wdata | input | DW | Store or swap data |
| cpu_rsp_valid | output | 1 | One-cycle pulse carrying a load or swap result |
| cpu_rsp_data | output | DW | Load or swap result |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_op | output | 2 | 0 read, 1 write, 2 swap |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Write or swap data |
| mem_rsp_valid | input | 1 | Response to the outstanding request |
| mem_rsp_data | input | DW | Read or swap old value |

## Verification
The bench builds the block with the default depth of 8, an 8-bit address and 32-bit data, so the queue can be filled completely with a small directed sequence and the full back-pressure case is reached directly. Holding the memory model's ready low keeps stores parked, which makes forwarding from several same-address entries observable, and a partial drain before refilling moves the head so the youngest match has to be found across the pointer wrap. Swap ordering is exposed by queuing a store and a swap to one address and checking that the swap returns the stored data.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    typedef enum logic [1:0] {
        CPU_LOAD  = 2'd0,
        CPU_STORE = 2'd1,
        CPU_SWAP  = 2'd2
    } cpu_op_e;

    typedef enum logic [1:0] {
        MEM_READ  = 2'd0,
        MEM_WRITE = 2'd1,
        MEM_SWAP  = 2'd2
    } mem_op_e;

    typedef enum logic [1:0] {
        MP_IDLE = 2'd0,
        MP_REQ  = 2'd1,
        MP_RSP  = 2'd2
    } mport_e;

endpackage

// File: rtl/tsq_fwd_pick.sv
// Picks the youngest matching entry; index 0 is the oldest, N-1 the youngest.
module tsq_fwd_pick #(
    parameter int N  = 8,
    parameter int DW = 32
) (
    input  logic [N-1:0]  match_i,
    input  logic [DW-1:0] data_i [N],
    output logic          hit_o,
    output logic [DW-1:0] data_o
);

    always_comb begin
        data_o = '0;
        for (int i = 0; i < N; i++) begin
            if (match_i[i]) begin
                data_o = data_i[i];
            end
        end
    end

    assign hit_o = |match_i;

endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          push_swap_i,
    input  logic          pop_i,
    input  logic [AW-1:0] lk_addr_i,
    output logic          lk_hit_o,
    output logic [DW-1:0] lk_data_o,
    output logic          empty_o,
    output logic          full_o,
    output logic [AW-1:0] head_addr_o,
    output logic [DW-1:0] head_data_o,
    output logic          head_swap_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    logic [AW-1:0] slot_addr_q [DEPTH];
    logic [DW-1:0] slot_data_q [DEPTH];
    logic          slot_swap_q [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (push_i) begin
            ptr_d.tail = wrap_inc(ptr_q.tail);
        end
        if (pop_i) begin
            ptr_d.head = wrap_inc(ptr_q.head);
        end
        case ({push_i, pop_i})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            slot_addr_q[ptr_q.tail] <= push_addr_i;
            slot_data_q[ptr_q.tail] <= push_data_i;
            slot_swap_q[ptr_q.tail] <= push_swap_i;
        end
    end

    // Present the slots in age order (0 = oldest) for the forwarding search.
    logic [DEPTH-1:0] age_hit;
    logic [DW-1:0]    age_data [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [PW:0]   sum;
        logic [PW-1:0] idx;
        assign sum = {1'b0, ptr_q.head} + (PW+1)'(g);
        assign idx = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH)) : PW'(sum);
        assign age_hit[g]  = (CW'(g) < ptr_q.cnt) && !slot_swap_q[idx]
                             && (slot_addr_q[idx] == lk_addr_i);
        assign age_data[g] = slot_data_q[idx];
    end

    tsq_fwd_pick #(
        .N  (DEPTH),
        .DW (DW)
    ) pick_i (
        .match_i (age_hit),
        .data_i  (age_data),
        .hit_o   (lk_hit_o),
        .data_o  (lk_data_o)
    );

    assign empty_o     = (ptr_q.cnt == '0);
    assign full_o      = (ptr_q.cnt == CW'(DEPTH));
    assign head_addr_o = slot_addr_q[ptr_q.head];
    assign head_data_o = slot_data_q[ptr_q.head];
    assign head_swap_o = slot_swap_q[ptr_q.head];

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (ptr_q.cnt != CW'(DEPTH)));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (ptr_q.cnt != '0));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.cnt <= CW'(DEPTH));

endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
    import tsq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid_i,
    output logic          cpu_req_ready_o,
    input  logic [1:0]    cpu_req_op_i,
    input  logic [AW-1:0] cpu_req_addr_i,
    input  logic [DW-1:0] cpu_req_wdata_i,
    output logic          cpu_rsp_valid_o,
    output logic [DW-1:0] cpu_rsp_data_o,
    output logic          push_o,
    output logic          push_swap_o,
    output logic          pop_o,
    input  logic          lk_hit_i,
    input  logic [DW-1:0] lk_data_i,
    input  logic          empty_i,
    input  logic          full_i,
    input  logic [AW-1:0] head_addr_i,
    input  logic [DW-1:0] head_data_i,
    input  logic          head_swap_i,
    output logic          mem_req_valid_o,
    input  logic          mem_req_ready_i,
    output logic [1:0]    mem_req_op_o,
    output logic [AW-1:0] mem_req_addr_o,
    output logic [DW-1:0] mem_req_wdata_o,
    input  logic          mem_rsp_valid_i,
    input  logic [DW-1:0] mem_rsp_data_i
);

    typedef struct packed {
        mport_e        mp;
        logic          from_load;
        mem_op_e       mop;
        logic [AW-1:0] maddr;
        logic [DW-1:0] mdata;
        logic          ld_pend;
        logic [AW-1:0] ld_addr;
        logic          sw_pend;
        logic          rsp_v;
        logic [DW-1:0] rsp_d;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic blocked;
    logic op_load, op_store, op_swap;
    logic accept;

    assign blocked  = ctl_q.ld_pend | ctl_q.sw_pend;
    assign op_load  = (cpu_req_op_i == CPU_LOAD);
    assign op_store = (cpu_req_op_i == CPU_STORE);
    assign op_swap  = (cpu_req_op_i == CPU_SWAP);

    assign cpu_req_ready_o = !blocked && (op_load || ((op_store || op_swap) && !full_i));
    assign accept          = cpu_req_valid_i && cpu_req_ready_o;

    assign push_o      = accept && (op_store || op_swap);
    assign push_swap_o = op_swap;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        pop_o       = 1'b0;

        // processor side
        if (accept && op_swap) begin
            ctl_d.sw_pend = 1'b1;
        end
        if (accept && op_load) begin
            if (lk_hit_i) begin
                ctl_d.rsp_v = 1'b1;
                ctl_d.rsp_d = lk_data_i;
            end else begin
                ctl_d.ld_pend = 1'b1;
                ctl_d.ld_addr = cpu_req_addr_i;
            end
        end

        // memory side: queued entries first, a missing load only on an empty queue
        case (ctl_q.mp)
            MP_IDLE: begin
                if (!empty_i) begin
                    ctl_d.mp        = MP_REQ;
                    ctl_d.from_load = 1'b0;
                    ctl_d.mop       = head_swap_i ? MEM_SWAP : MEM_WRITE;
                    ctl_d.maddr     = head_addr_i;
                    ctl_d.mdata     = head_data_i;
                end else if (ctl_q.ld_pend) begin
                    ctl_d.mp        = MP_REQ;
                    ctl_d.from_load = 1'b1;
                    ctl_d.mop       = MEM_READ;
                    ctl_d.maddr     = ctl_q.ld_addr;
                    ctl_d.mdata     = '0;
                end
            end
            MP_REQ: begin
                if (mem_req_ready_i) begin
                    ctl_d.mp = MP_RSP;
                end
            end
            MP_RSP: begin
                if (mem_rsp_valid_i) begin
                    ctl_d.mp = MP_IDLE;
                    if (ctl_q.from_load) begin
                        ctl_d.ld_pend = 1'b0;
                        ctl_d.rsp_v   = 1'b1;
                        ctl_d.rsp_d   = mem_rsp_data_i;
                    end else begin
                        pop_o = 1'b1;
                        if (ctl_q.mop == MEM_SWAP) begin
                            ctl_d.sw_pend = 1'b0;
                            ctl_d.rsp_v   = 1'b1;
                            ctl_d.rsp_d   = mem_rsp_data_i;
                        end
                    end
                end
            end
            default: ctl_d.mp = MP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req_valid_o = (ctl_q.mp == MP_REQ);
    assign mem_req_op_o    = ctl_q.mop;
    assign mem_req_addr_o  = ctl_q.maddr;
    assign mem_req_wdata_o = ctl_q.mdata;
    assign cpu_rsp_valid_o = ctl_q.rsp_v;
    assign cpu_rsp_data_o  = ctl_q.rsp_d;

    assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=>
            (mem_req_valid_o && $stable(mem_req_op_o) && $stable(mem_req_addr_o)
             && $stable(mem_req_wdata_o)));

    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

    assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !cpu_req_ready_o);

    assert_read_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_op_o == MEM_READ) |-> empty_i);

    assert_full_backpressure_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_i && !op_load) |-> !cpu_req_ready_o);

    assert_hit_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_load && lk_hit_i) |=> cpu_rsp_valid_o);

endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic [1:0]    cpu_req_op,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    output logic          cpu_rsp_valid,
    output logic [DW-1:0] cpu_rsp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [1:0]    mem_req_op,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);

    logic          push, push_swap, pop;
    logic          lk_hit;
    logic [DW-1:0] lk_data;
    logic          q_empty, q_full;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic          head_swap;

    tsq_fifo #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW)
    ) fifo_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_addr_i (cpu_req_addr),
        .push_data_i (cpu_req_wdata),
        .push_swap_i (push_swap),
        .pop_i       (pop),
        .lk_addr_i   (cpu_req_addr),
        .lk_hit_o    (lk_hit),
        .lk_data_o   (lk_data),
        .empty_o     (q_empty),
        .full_o      (q_full),
        .head_addr_o (head_addr),
        .head_data_o (head_data),
        .head_swap_o (head_swap)
    );

    tsq_ctrl #(
        .AW (AW),
        .DW (DW)
    ) ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cpu_req_valid_i (cpu_req_valid),
        .cpu_req_ready_o (cpu_req_ready),
        .cpu_req_op_i    (cpu_req_op),
        .cpu_req_addr_i  (cpu_req_addr),
        .cpu_req_wdata_i (cpu_req_wdata),
        .cpu_rsp_valid_o (cpu_rsp_valid),
        .cpu_rsp_data_o  (cpu_rsp_data),
        .push_o          (push),
        .push_swap_o     (push_swap),
        .pop_o           (pop),
        .lk_hit_i        (lk_hit),
        .lk_data_i       (lk_data),
        .empty_i         (q_empty),
        .full_i          (q_full),
        .head_addr_i     (head_addr),
        .head_data_i     (head_data),
        .head_swap_i     (head_swap),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_ready_i (mem_req_ready),
        .mem_req_op_o    (mem_req_op),
        .mem_req_addr_o  (mem_req_addr),
        .mem_req_wdata_o (mem_req_wdata),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_data_i  (mem_rsp_data)
    );

endmodule

// File: tb/tso_store_queue_tb_top.sv
module tso_store_queue_tb_top;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_ready;
    logic [1:0]    cpu_req_op = 2'd0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_data;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic [1:0]    mem_req_op;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid;
    logic [DW-1:0] mem_rsp_data;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tso_store_queue #(.DEPTH(8), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_op(cpu_req_op), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // memory model: initial contents 0xA000_0000 | address, answers one cycle after acceptance
    logic          mem_en = 1'b0;
    logic [DW-1:0] mem [256];
    logic [1:0]    log_op [64];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int            log_n = 0;

    assign mem_req_ready = mem_en;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 | i;
            mem_rsp_data <= '0;
        end else if (mem_req_valid && mem_req_ready) begin
            case (mem_req_op)
                2'd0: mem_rsp_data <= mem[mem_req_addr];
                2'd1: begin mem[mem_req_addr] <= mem_req_wdata; mem_rsp_data <= '0; end
                default: begin
                    mem_rsp_data <= mem[mem_req_addr];
                    mem[mem_req_addr] <= mem_req_wdata;
                end
            endcase
            if (log_n < 64) begin
                log_op[log_n]   <= mem_req_op;
                log_addr[log_n] <= mem_req_addr;
                log_data[log_n] <= mem_req_wdata;
            end
            log_n <= log_n + 1;
            mem_rsp_valid <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output bit ok);
        ok = 1'b0;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_op    = op;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        for (int k = 0; k < 100; k++) begin
            #1;
            if (cpu_req_ready) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (ok) begin
            @(posedge clk);
            @(negedge clk);
        end
        cpu_req_valid = 1'b0;
    endtask

    task automatic wait_rsp(output bit got, output logic [DW-1:0] d);
        got = 1'b0;
        d = '0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (cpu_rsp_valid) begin
                got = 1'b1;
                d = cpu_rsp_data;
                break;
            end
        end
    endtask

    task automatic wait_log(input int target);
        for (int k = 0; k < 500 && log_n < target; k++) @(negedge clk);
    endtask

    task automatic check_log(input int idx, input logic [1:0] op, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input string req);
        check(log_op[idx] == op, req, "mem op order", 32'(log_op[idx]), 32'(op));
        check(log_addr[idx] == a, req, "mem addr order", 32'(log_addr[idx]), 32'(a));
        if (op != 2'd0)
            check(log_data[idx] == d, req, "mem data order", log_data[idx], d);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        check(cpu_req_ready == 1'b1, "R1", "ready after reset", 32'(cpu_req_ready), 1);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 0);
        check(cpu_rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(cpu_rsp_valid), 0);
    endtask

    // R2, R4, R5, R6, R3: fill while memory stalls, forward, then miss
    task automatic t_fill_forward_miss();
        bit ok;
        bit got;
        logic [DW-1:0] d;
        int base;
        logic [AW-1:0] aa [8];
        logic [DW-1:0] dd [8];
        aa = '{8'h10, 8'h20, 8'h10, 8'h30, 8'h40, 8'h50, 8'h60, 8'h10};
        for (int i = 0; i < 8; i++) dd[i] = 32'h1100_0000 + i;
        mem_en = 1'b0;
        base = log_n;
        for (int i = 0; i < 8; i++) begin
            issue(2'd1, aa[i], dd[i], ok);
            check(ok, "R2", "store accepted below depth", 32'(ok), 1);
        end
        @(negedge clk);
        cpu_req_op = 2'd1;
        #1;
        check(cpu_req_ready == 1'b0, "R2", "store ready when full", 32'(cpu_req_ready), 0);
        cpu_req_op = 2'd2;
        #1;
        check(cpu_req_ready == 1'b0, "R2", "swap ready when full", 32'(cpu_req_ready), 0);
        cpu_req_op = 2'd0;
        #1;
        check(cpu_req_ready == 1'b1, "R2", "load ready when full", 32'(cpu_req_ready), 1);
        check(mem_req_valid && mem_req_addr == 8'h10 && mem_req_op == 2'd1, "R8",
              "head request held", 32'(mem_req_addr), 32'h10);

        issue(2'd0, 8'h10, '0, ok);
        check(cpu_rsp_valid == 1'b1, "R4", "hit rsp one cycle after accept", 32'(cpu_rsp_valid), 1);
        check(cpu_rsp_data == dd[7], "R4", "youngest of three matches", cpu_rsp_data, dd[7]);
        issue(2'd0, 8'h20, '0, ok);
        check(cpu_rsp_valid && cpu_rsp_data == dd[1], "R4", "single match", cpu_rsp_data, dd[1]);
        check(log_n == base, "R4", "no memory traffic on hits", 32'(log_n), 32'(base));

        issue(2'd0, 8'h77, '0, ok);
        check(cpu_req_ready == 1'b0, "R6", "blocked after load miss", 32'(cpu_req_ready), 0);
        for (int k = 0; k < 4; k++) @(negedge clk);
        check(cpu_rsp_valid == 1'b0, "R6", "no answer while stalled", 32'(cpu_rsp_valid), 0);
        check(cpu_req_ready == 1'b0, "R6", "still blocked while stalled", 32'(cpu_req_ready), 0);
        mem_en = 1'b1;
        wait_rsp(got, d);
        check(got, "R5", "miss answered", 32'(got), 1);
        check(d == 32'hA000_0077, "R5", "miss data from memory", d, 32'hA000_0077);
        check(cpu_req_ready == 1'b1, "R6", "unblocked after answer", 32'(cpu_req_ready), 1);
        for (int i = 0; i < 8; i++) check_log(base + i, 2'd1, aa[i], dd[i], "R3");
        check_log(base + 8, 2'd0, 8'h77, '0, "R5");
    endtask

    // R4, R3 across pointer wrap
    task automatic t_wrap_forward();
        bit ok;
        int base;
        logic [AW-1:0] aa [6];
        logic [DW-1:0] dd [6];
        aa = '{8'h05, 8'h06, 8'h05, 8'h07, 8'h08, 8'h05};
        for (int i = 0; i < 6; i++) dd[i] = 32'h2200_0000 + i;
        mem_en = 1'b1;
        base = log_n;
        for (int i = 0; i < 3; i++) issue(2'd1, 8'(8'h01 + i), 32'h3300_0000 + i, ok);
        wait_log(base + 3);
        for (int k = 0; k < 4; k++) @(negedge clk);
        mem_en = 1'b0;
        base = log_n;
        for (int i = 0; i < 6; i++) issue(2'd1, aa[i], dd[i], ok);
        issue(2'd0, 8'h05, '0, ok);
        check(cpu_rsp_valid && cpu_rsp_data == dd[5], "R4", "youngest across wrap",
              cpu_rsp_data, dd[5]);
        issue(2'd0, 8'h06, '0, ok);
        check(cpu_rsp_valid && cpu_rsp_data == dd[1], "R4", "older match across wrap",
              cpu_rsp_data, dd[1]);
        mem_en = 1'b1;
        wait_log(base + 6);
        for (int i = 0; i < 6; i++) check_log(base + i, 2'd1, aa[i], dd[i], "R3");
        for (int k = 0; k < 4; k++) @(negedge clk);
    endtask

    // R7, R6
    task automatic t_swap();
        bit ok;
        bit got;
        logic [DW-1:0] d;
        int base;
        mem_en = 1'b0;
        base = log_n;
        issue(2'd1, 8'h44, 32'h5555_0001, ok);
        issue(2'd2, 8'h44, 32'h5555_0002, ok);
        check(ok, "R7", "swap accepted", 32'(ok), 1);
        check(cpu_req_ready == 1'b0, "R6", "blocked during swap", 32'(cpu_req_ready), 0);
        mem_en = 1'b1;
        wait_rsp(got, d);
        check(got && d == 32'h5555_0001, "R7", "swap returns value of older store",
              d, 32'h5555_0001);
        check_log(base, 2'd1, 8'h44, 32'h5555_0001, "R7");
        check_log(base + 1, 2'd2, 8'h44, 32'h5555_0002, "R7");
        issue(2'd0, 8'h44, '0, ok);
        wait_rsp(got, d);
        check(got && d == 32'h5555_0002, "R7", "swap wrote new value", d, 32'h5555_0002);
        issue(2'd2, 8'h90, 32'h6666_0000, ok);
        wait_rsp(got, d);
        check(got && d == 32'hA000_0090, "R7", "swap on untouched address", d, 32'hA000_0090);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_forward_miss();
        t_wrap_forward();
        t_swap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule